// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block decides which operating mode a small microcontroller core is in: full-speed active mode, a watch mode in which only the time base runs, and a subactive mode in which the core runs from the slow subclock. Decoded STOP and SBY instruction strobes move the core into the low-power modes. A timer-control select bit decides whether STOP enters watch mode. Two mode-control flags, a low-speed flag and a direct-transfer flag, choose where a wake-up or a subactive exit leads.

When the core leaves watch mode or subactive mode for active mode, the main oscillator enable rises first. While the oscillator settles, the CPU stays on the subclock and interrupt delivery is held. The settle window is longer when the external interrupt or the wake-up pin caused the wake, because such requests are not aligned to the interrupt frame. When the window ends, the CPU clock switches to the main clock and the hold is released.

The block also keeps the flag register, the subactive speed-select bit and a sticky flag that records writes to that bit made outside active mode.

Top module: `lpm_top`

## Requirements
- R1: After reset the outputs are as follows: `mode` is active (2'b00), `mainOscEn`=1, `cpuClkMain`=1, `adcEn`=1, `irqHold`=0, and `lsonQ`, `dtonQ`, `spdSel` and `spdErr` are all 0. A reset applied during a settle window ends the hold and returns the block to full active mode.
- R2: In full active mode, `stopStb` with `watchSel`=1 sets `mode` to watch (2'b01) in the next cycle. `stopStb` with `watchSel`=0 has no effect on the mode, and neither has `sbyStb`.
- R3: In watch mode, a wake request on `extIrq`, `tmrIrq` or `pinIrq` while `lsonQ`=1 sets `mode` to subactive (2'b10) in the next cycle.
- R4: In watch mode, a wake request while `lsonQ`=0 starts a settle window in the next cycle. During the window `mode`=2'b00, `mainOscEn`=1, `cpuClkMain`=0, `adcEn`=0 and `irqHold`=1.
- R5: A wake caused by `tmrIrq` alone lasts SETTLE_CYC cycles. A wake in which `extIrq` or `pinIrq` is high lasts SETTLE_CYC+FRAME_CYC cycles. When the window ends, `cpuClkMain` and `adcEn` become 1 and `irqHold` becomes 0 in the same cycle.
- R6: In subactive mode, `stopStb` or `sbyStb` ends the mode. With `dtonQ`=1 and `lsonQ`=0 the block enters a settle window of SETTLE_CYC cycles and then full active mode. Every other flag combination leads to watch mode.
- R7: In watch mode and in subactive mode, `mainOscEn`, `cpuClkMain`, `adcEn` and `irqHold` are all 0.
- R8: While `mode` is active (full or settling), `spdWrEn` loads `spdIn` into `spdSel` in the next cycle. In any other mode the write leaves `spdSel` unchanged and sets `spdErr`, which stays 1 until reset.
- R9: `flagWrEn` loads `lsonIn` into `lsonQ` and `dtonIn` into `dtonQ` in the next cycle, in any mode.
- R10: Wake requests have no effect on the mode in full active mode or in subactive mode. Instruction strobes have no effect during a settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stopStb | input | 1 | Decoded STOP instruction, one-cycle strobe |
| sbyStb | input | 1 | Decoded SBY instruction, one-cycle strobe |
| watchSel | input | 1 | Timer-control select: STOP enters watch mode when set |
| flagWrEn | input | 1 | Write strobe for the mode-control flags |
| lsonIn | input | 1 | Low-speed flag write data |
| dtonIn | input | 1 | Direct-transfer flag write data |
| spdWrEn | input | 1 | Write strobe for the subactive speed select |
| spdIn | input | 1 | Speed-select write data |
| extIrq | input | 1 | External interrupt wake request |
| tmrIrq | input | 1 | Timer wake request (frame aligned) |
| pinIrq | input | 1 | Wake-up pin request |
| mode | output | 2 | 00 active, 01 watch, 10 subactive |
| mainOscEn | output | 1 | Main oscillator enable |
| cpuClkMain | output | 1 | 1: CPU runs on main clock, 0: on subclock |
| adcEn | output | 1 | A/D converter enable |
| irqHold | output | 1 | Interrupt delivery held during oscillator settle |
| lsonQ | output | 1 | Low-speed flag |
| dtonQ | output | 1 | Direct-transfer flag |
| spdSel | output | 1 | Subactive instruction period select (0: 244 µs, 1: 122 µs) |
| spdErr | output | 1 | Sticky: speed select written outside active mode |

## Verification
The assertions assume that every input is synchronous to `clk` and carries a known value from the first edge after reset. They also assume that the mode decision in any cycle uses the flag values already registered, so a flag write and a strobe in the same cycle resolve on the old flags. The bench drives every input on the falling edge and pulses the strobes for exactly one cycle. It changes the flags in cycles before the mode-changing strobe, so each check reads a well-defined flag state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_WATCH  = 2'b01,
    MODE_SUB    = 2'b10
  } lpmMode_e;

  typedef enum logic [1:0] {
    ST_ACT    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WATCH  = 2'd2,
    ST_SUB    = 2'd3
  } lpmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSettle;
    logic longSettle;
    logic spdWrOk;
    logic spdWrBad;
  } lpmStb_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopStb,
  input  logic       sbyStb,
  input  logic       watchSel,
  input  logic       spdWrEn,
  input  logic       extIrq,
  input  logic       tmrIrq,
  input  logic       pinIrq,
  input  logic       lsonQ,
  input  logic       dtonQ,
  input  logic       settleDone,
  output lpmStb_t    stb,
  output logic [1:0] mode,
  output logic       mainOscEn,
  output logic       cpuClkMain,
  output logic       adcEn,
  output logic       irqHold
);

  lpmState_e stateQ, stateD;
  logic      anyWake;
  logic      asyncWake;
  logic      subExit;
  logic      directXfer;

  assign anyWake    = extIrq | tmrIrq | pinIrq;
  assign asyncWake  = extIrq | pinIrq;
  assign subExit    = stopStb | sbyStb;
  assign directXfer = dtonQ & ~lsonQ;

  always_comb begin
    stateD         = stateQ;
    stb            = '0;
    unique case (stateQ)
      ST_ACT: begin
        if (stopStb && watchSel) stateD = ST_WATCH;
      end
      ST_SETTLE: begin
        if (settleDone) stateD = ST_ACT;
      end
      ST_WATCH: begin
        if (anyWake) begin
          if (lsonQ) begin
            stateD = ST_SUB;
          end else begin
            stateD         = ST_SETTLE;
            stb.loadSettle = 1'b1;
            stb.longSettle = asyncWake;
          end
        end
      end
      ST_SUB: begin
        if (subExit) begin
          if (directXfer) begin
            stateD         = ST_SETTLE;
            stb.loadSettle = 1'b1;
            stb.longSettle = 1'b0;
          end else begin
            stateD = ST_WATCH;
          end
        end
      end
      default: stateD = ST_ACT;
    endcase

    if (spdWrEn) begin
      if (stateQ == ST_ACT || stateQ == ST_SETTLE) stb.spdWrOk  = 1'b1;
      else                                         stb.spdWrBad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACT;
    else       stateQ <= stateD;
  end

  // outputs decoded from the state register
  always_comb begin
    mode       = MODE_ACTIVE;
    mainOscEn  = 1'b1;
    cpuClkMain = 1'b1;
    adcEn      = 1'b1;
    irqHold    = 1'b0;
    unique case (stateQ)
      ST_ACT: ;
      ST_SETTLE: begin
        cpuClkMain = 1'b0;
        adcEn      = 1'b0;
        irqHold    = 1'b1;
      end
      ST_WATCH: begin
        mode       = MODE_WATCH;
        mainOscEn  = 1'b0;
        cpuClkMain = 1'b0;
        adcEn      = 1'b0;
      end
      ST_SUB: begin
        mode       = MODE_SUB;
        mainOscEn  = 1'b0;
        cpuClkMain = 1'b0;
        adcEn      = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int FRAME_CYC  = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  lpmStb_t stb,
  input  logic    flagWrEn,
  input  logic    lsonIn,
  input  logic    dtonIn,
  input  logic    spdIn,
  output logic    settleDone,
  output logic    lsonQ,
  output logic    dtonQ,
  output logic    spdSel,
  output logic    spdErr
);

  localparam int LONG_CYC = SETTLE_CYC + FRAME_CYC;
  localparam int CNT_W    = $clog2(LONG_CYC + 1);

  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] longLoad;
  logic [CNT_W-1:0] settleCnt;

  generate
    if (FRAME_CYC > 0) begin : g_frameAdd
      assign longLoad = CNT_W'(LONG_CYC - 1);
    end else begin : g_noFrame
      assign longLoad = SHORT_LOAD;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (stb.loadSettle) begin
      settleCnt <= stb.longSettle ? longLoad : SHORT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign settleDone = (settleCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsonQ <= 1'b0;
      dtonQ <= 1'b0;
    end else if (flagWrEn) begin
      lsonQ <= lsonIn;
      dtonQ <= dtonIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spdSel <= 1'b0;
      spdErr <= 1'b0;
    end else begin
      if (stb.spdWrOk)  spdSel <= spdIn;
      if (stb.spdWrBad) spdErr <= 1'b1;
    end
  end

endmodule

// File: rtl/lpm_top.sv
module lpm_top
  import lpm_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int FRAME_CYC  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopStb,
  input  logic       sbyStb,
  input  logic       watchSel,
  input  logic       flagWrEn,
  input  logic       lsonIn,
  input  logic       dtonIn,
  input  logic       spdWrEn,
  input  logic       spdIn,
  input  logic       extIrq,
  input  logic       tmrIrq,
  input  logic       pinIrq,
  output logic [1:0] mode,
  output logic       mainOscEn,
  output logic       cpuClkMain,
  output logic       adcEn,
  output logic       irqHold,
  output logic       lsonQ,
  output logic       dtonQ,
  output logic       spdSel,
  output logic       spdErr
);

  lpmStb_t stb;
  logic    settleDone;

  lpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stopStb   (stopStb),
    .sbyStb    (sbyStb),
    .watchSel  (watchSel),
    .spdWrEn   (spdWrEn),
    .extIrq    (extIrq),
    .tmrIrq    (tmrIrq),
    .pinIrq    (pinIrq),
    .lsonQ     (lsonQ),
    .dtonQ     (dtonQ),
    .settleDone(settleDone),
    .stb       (stb),
    .mode      (mode),
    .mainOscEn (mainOscEn),
    .cpuClkMain(cpuClkMain),
    .adcEn     (adcEn),
    .irqHold   (irqHold)
  );

  lpm_dp #(
    .SETTLE_CYC(SETTLE_CYC),
    .FRAME_CYC (FRAME_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .flagWrEn  (flagWrEn),
    .lsonIn    (lsonIn),
    .dtonIn    (dtonIn),
    .spdIn     (spdIn),
    .settleDone(settleDone),
    .lsonQ     (lsonQ),
    .dtonQ     (dtonQ),
    .spdSel    (spdSel),
    .spdErr    (spdErr)
  );

endmodule

// File: rtl/lpm_chk.sv
module lpm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stopStb,
  input logic       sbyStb,
  input logic       watchSel,
  input logic       extIrq,
  input logic       tmrIrq,
  input logic       pinIrq,
  input logic       spdWrEn,
  input logic [1:0] mode,
  input logic       mainOscEn,
  input logic       cpuClkMain,
  input logic       adcEn,
  input logic       irqHold,
  input logic       lsonQ,
  input logic       dtonQ,
  input logic       spdSel,
  input logic       spdErr
);

  logic wakeAny;
  assign wakeAny = extIrq | tmrIrq | pinIrq;

  // R2
  stop_to_watch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && cpuClkMain && stopStb && watchSel) |=> (mode == 2'b01));

  // R3
  wake_to_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && wakeAny && lsonQ) |=> (mode == 2'b10));

  // R4
  wake_to_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && wakeAny && !lsonQ) |=> (mode == 2'b00 && mainOscEn && !cpuClkMain && irqHold));

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqHold) |-> (cpuClkMain && adcEn));

  // R6
  sub_to_watch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && (stopStb || sbyStb) && !(dtonQ && !lsonQ)) |=> (mode == 2'b01));

  // R7
  low_power_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |-> (!mainOscEn && !cpuClkMain && !adcEn && !irqHold));

  // R8
  spd_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |=> $stable(spdSel));

  // R8
  spd_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    spdErr |=> spdErr);

  // R8
  spd_err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00 && spdWrEn) |=> spdErr);

  // R10
  sub_ignores_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10 && !stopStb && !sbyStb) |=> (mode == 2'b10));

  // R1
  clk_needs_osc_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkMain |-> mainOscEn);

endmodule

bind lpm_top lpm_chk u_chk (.*);

// File: tb/lpm_top_tb.sv
`timescale 1ns/1ps
module lpm_top_tb;

  localparam int SETTLE = 8;
  localparam int FRAME  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopStb = 0, sbyStb = 0, watchSel = 0;
  logic flagWrEn = 0, lsonIn = 0, dtonIn = 0;
  logic spdWrEn = 0, spdIn = 0;
  logic extIrq = 0, tmrIrq = 0, pinIrq = 0;
  logic [1:0] mode;
  logic mainOscEn, cpuClkMain, adcEn, irqHold, lsonQ, dtonQ, spdSel, spdErr;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  lpm_top #(.SETTLE_CYC(SETTLE), .FRAME_CYC(FRAME)) u_dut (
    .clk(clk), .rstN(rstN), .stopStb(stopStb), .sbyStb(sbyStb),
    .watchSel(watchSel), .flagWrEn(flagWrEn), .lsonIn(lsonIn),
    .dtonIn(dtonIn), .spdWrEn(spdWrEn), .spdIn(spdIn), .extIrq(extIrq),
    .tmrIrq(tmrIrq), .pinIrq(pinIrq), .mode(mode), .mainOscEn(mainOscEn),
    .cpuClkMain(cpuClkMain), .adcEn(adcEn), .irqHold(irqHold),
    .lsonQ(lsonQ), .dtonQ(dtonQ), .spdSel(spdSel), .spdErr(spdErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // packs {mode, osc, clkMain, adc, hold}
  function automatic int outs();
    return {26'd0, mode, mainOscEn, cpuClkMain, adcEn, irqHold};
  endfunction
  localparam int O_ACT    = 6'b00_1110;
  localparam int O_SETTLE = 6'b00_1001;
  localparam int O_WATCH  = 6'b01_0000;
  localparam int O_SUB    = 6'b10_0000;

  task automatic doReset();
    @(negedge clk); rstN = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
    @(negedge clk);
  endtask

  task automatic setFlags(input logic l, input logic d);
    @(negedge clk); flagWrEn = 1; lsonIn = l; dtonIn = d;
    @(negedge clk); flagWrEn = 0;
  endtask

  task automatic stopWatch();
    @(negedge clk); stopStb = 1; watchSel = 1;
    @(negedge clk); stopStb = 0; watchSel = 0;
  endtask

  task automatic wake(input logic e, input logic t, input logic p);
    @(negedge clk); extIrq = e; tmrIrq = t; pinIrq = p;
    @(negedge clk); extIrq = 0; tmrIrq = 0; pinIrq = 0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 outputs", outs(), O_ACT);
    chk("R1 flags/spd/err", {lsonQ, dtonQ, spdSel, spdErr}, 0);
  endtask

  task automatic t_activeStop();
    @(negedge clk); stopStb = 1; watchSel = 0;
    @(negedge clk); stopStb = 0;
    chk("R2 stop without select", outs(), O_ACT);
    @(negedge clk); sbyStb = 1;
    @(negedge clk); sbyStb = 0;
    chk("R2 sby in active", outs(), O_ACT);
    wake(1, 1, 1);
    chk("R10 wake in active", outs(), O_ACT);
    stopWatch();
    chk("R2 stop to watch", outs(), O_WATCH);
    chk("R7 watch outputs", outs(), O_WATCH);
  endtask

  task automatic settleRun(input string req, input int len);
    chk({req, " settle start"}, outs(), O_SETTLE);
    waitCyc(len - 1);
    chk({req, " settle last"}, outs(), O_SETTLE);
    waitCyc(1);
    chk({req, " settle end"}, outs(), O_ACT);
  endtask

  task automatic t_wakeTimer();
    doReset(); stopWatch();
    wake(0, 1, 0);
    chk("R4 timer wake", outs(), O_SETTLE);
    @(negedge clk); stopStb = 1; watchSel = 1;
    @(negedge clk); stopStb = 0; watchSel = 0;
    chk("R10 strobe in settle", outs(), O_SETTLE);
    waitCyc(SETTLE - 3);
    chk("R5 timer last", outs(), O_SETTLE);
    waitCyc(1);
    chk("R5 timer end", outs(), O_ACT);
  endtask

  task automatic t_wakeExt();
    doReset(); stopWatch(); wake(1, 0, 0);
    settleRun("R5 ext", SETTLE + FRAME);
    stopWatch(); wake(0, 1, 1);
    settleRun("R5 pin", SETTLE + FRAME);
  endtask

  task automatic t_sub();
    doReset(); setFlags(1, 0); stopWatch();
    wake(0, 0, 1);
    chk("R3 wake to sub", outs(), O_SUB);
    chk("R7 sub outputs", outs(), O_SUB);
    wake(1, 1, 1);
    chk("R10 wake in sub", outs(), O_SUB);
    // lson=1,dton=1 -> watch
    setFlags(1, 1);
    @(negedge clk); sbyStb = 1;
    @(negedge clk); sbyStb = 0;
    chk("R6 sub exit lson", outs(), O_WATCH);
    setFlags(1, 0); wake(1, 0, 0);
    chk("R3 again", outs(), O_SUB);
    setFlags(0, 0);
    @(negedge clk); stopStb = 1;
    @(negedge clk); stopStb = 0;
    chk("R6 sub exit none", outs(), O_WATCH);
    setFlags(1, 1); wake(0, 1, 0);
    setFlags(0, 1);
    chk("R9 flags", {lsonQ, dtonQ}, 1);
    @(negedge clk); stopStb = 1;
    @(negedge clk); stopStb = 0;
    settleRun("R6 direct", SETTLE);
  endtask

  task automatic t_spd();
    doReset();
    @(negedge clk); spdWrEn = 1; spdIn = 1;
    @(negedge clk); spdWrEn = 0;
    chk("R8 write in active", spdSel, 1);
    chk("R8 no err", spdErr, 0);
    stopWatch();
    @(negedge clk); spdWrEn = 1; spdIn = 0;
    @(negedge clk); spdWrEn = 0;
    chk("R8 ignored in watch", spdSel, 1);
    chk("R8 err set", spdErr, 1);
    wake(0, 1, 0); waitCyc(SETTLE);
    chk("R8 err sticky", spdErr, 1);
  endtask

  task automatic t_resetSettle();
    doReset(); stopWatch(); wake(1, 0, 0);
    chk("R4 before reset", outs(), O_SETTLE);
    doReset();
    chk("R1 reset drops hold", outs(), O_ACT);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_activeStop();
        t_wakeTimer();
        t_wakeExt();
        t_sub();
        t_spd();
        t_resetSettle();
      end
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule